// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a 16-bit down-counter that produces a periodic interrupt. A single-cycle register port reaches three halfword registers: a control word, a modulus, and a read-only view of the live count. An external clock-enable pulse (`tick_en`) is the base tick. It is divided by a power of two taken from the control word, and each divided tick moves the counter one step.

In reload mode the counter restarts from the modulus. In free-run mode it restarts from 0xFFFF. Each time the count becomes zero, a sticky flag is set. The interrupt line is the flag gated by an enable bit. Software clears the flag by writing one to it.

A write to the modulus can overwrite the running count at once. A control write that only toggles the interrupt enable leaves the counter and the prescaler undisturbed.

Top module: `pit_timer`

## Requirements
- R1: After synchronous reset, the control, modulus and count registers all read 0 and `irq` is low.
- R2: The control word at offset 0 has these fields: bit 0 enable, bit 1 reload, bit 2 flag, bit 3 interrupt enable, bit 4 overwrite, bit 5 debug, bit 6 doze, bits 11:8 prescale. Bits 7 and 15:12 read 0. Debug and doze are stored and read back, and they have no effect on counting.
- R3: Any control write leaves the flag clear, and a 1 written to bit 2 is never stored. If an expiry happens in the same cycle as a flag-clearing write, the flag ends up set.
- R4: `irq` is high exactly when the flag and the interrupt enable are both set.
- R5: While enabled, the counter steps once every 2^P pulses of `tick_en`, where P is the prescale field (0 to 15).
- R6: On a step, a count of zero is reloaded with the limit; any other count decrements. The limit is the modulus in reload mode and 0xFFFF otherwise. The flag is set on every step whose new count is zero, so a modulus of 0 sets it on every step.
- R7: A control write is a restart if it differs from the current value, after flag handling, in any bit other than interrupt enable. A restart zeroes the prescaler phase. With enable set, it loads the count with the limit. With enable clear, the count holds, and it keeps holding while disabled.
- R8: A control write that changes only the interrupt enable bit resets neither the count nor the prescaler phase.
- R9: A write to the modulus (offset 2) clears the flag. With overwrite set, the count is loaded with the written value at once, in either mode. With overwrite clear, the count is untouched and a new modulus takes effect at the next reload.
- R10: The count (offset 4) reads the live value and ignores writes. Any other offset reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base tick clock-enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Byte offset of the register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A register write and a counter step both take effect at the rising edge where `wr_en` or `tick_en` is sampled high. Reads are combinational, so every result is due in the cycle right after its stimulus. The bench drives the stimulus just after a rising edge and queues the expected read. It compares `rd_data` and `irq` at the following falling edge. Prescaler checks count `tick_en` pulses exactly, so a phase reset or a missing one moves the step by whole pulses.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int CNT_W  = 16;
    localparam int PRE_W  = 4;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_MOD  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd4;

    localparam int BIT_EN   = 0;
    localparam int BIT_RLD  = 1;
    localparam int BIT_FLAG = 2;
    localparam int BIT_IE   = 3;
    localparam int BIT_OVW  = 4;
    localparam int BIT_DBG  = 5;
    localparam int BIT_DOZE = 6;
    localparam int BIT_PRE  = 8;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             doze;
        logic             dbg;
        logic             ovw;
        logic             ie;
        logic             flag;
        logic             rld;
        logic             en;
    } ctrl_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_STEP,
        OP_LOAD_LIMIT,
        OP_LOAD_VALUE
    } cnt_op_e;

    function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.pre  = w[BIT_PRE +: PRE_W];
        c.doze = w[BIT_DOZE];
        c.dbg  = w[BIT_DBG];
        c.ovw  = w[BIT_OVW];
        c.ie   = w[BIT_IE];
        c.flag = w[BIT_FLAG];
        c.rld  = w[BIT_RLD];
        c.en   = w[BIT_EN];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w                  = '0;
        w[BIT_PRE +: PRE_W] = c.pre;
        w[BIT_DOZE]        = c.doze;
        w[BIT_DBG]         = c.dbg;
        w[BIT_OVW]         = c.ovw;
        w[BIT_IE]          = c.ie;
        w[BIT_FLAG]        = c.flag;
        w[BIT_RLD]         = c.rld;
        w[BIT_EN]          = c.en;
        return w;
    endfunction

    // True when two control values differ in anything but interrupt enable
    function automatic logic cfg_changed(input ctrl_t a, input ctrl_t b);
        ctrl_t x;
        ctrl_t y;
        x    = a;
        y    = b;
        x.ie = 1'b0;
        y.ie = 1'b0;
        return x != y;
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler
    import pit_pkg::*;
#(
    parameter int P_W = PRE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           restart,
    input  logic           run,
    input  logic           base_tick,
    input  logic [P_W-1:0] shift,
    output logic           step
);
    localparam int PH_W = (1 << P_W) - 1;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] ph_last;

    // 2^shift - 1; the top shift wraps to all ones, which is the right value
    always_comb ph_last = (PH_W'(1) << shift) - PH_W'(1);

    always_comb step = run && base_tick && !restart && (phase == ph_last);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            phase <= '0;
        end else if (base_tick) begin
            phase <= (phase == ph_last) ? '0 : phase + PH_W'(1);
        end
    end
endmodule

// File: rtl/pit_downcount.sv
module pit_downcount
    import pit_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_op_e      op,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         expire
);
    logic [W-1:0] stepped;
    logic [W-1:0] count_d;

    always_comb begin
        stepped = (count == '0) ? limit : count - W'(1);
        unique case (op)
            OP_STEP:       count_d = stepped;
            OP_LOAD_LIMIT: count_d = limit;
            OP_LOAD_VALUE: count_d = load_val;
            default:       count_d = count;
        endcase
        expire = (op == OP_STEP) && (stepped == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_d;
    end
endmodule

// File: rtl/pit_ctrl_regs.sv
module pit_ctrl_regs
    import pit_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wr_data,
    input  logic          expire,
    input  logic [W-1:0]  count,
    output ctrl_t         ctrl_q,
    output logic [W-1:0]  modulus,
    output logic          restart,
    output logic          ow_load,
    output logic [W-1:0]  rd_data
);
    logic  ctrl_wr;
    logic  mod_wr;
    ctrl_t wr_ctrl;
    ctrl_t old_eff;
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_wr = wr_en && (addr == OFS_CTRL);
        mod_wr  = wr_en && (addr == OFS_MOD);

        wr_ctrl      = word_to_ctrl(wr_data);
        wr_ctrl.flag = 1'b0;

        old_eff = ctrl_q;
        if (wr_data[BIT_FLAG]) old_eff.flag = 1'b0;

        restart = ctrl_wr && cfg_changed(old_eff, wr_ctrl);
        ow_load = mod_wr && ctrl_q.ovw;

        ctrl_d = ctrl_wr ? wr_ctrl : ctrl_q;
        if (mod_wr) ctrl_d.flag = 1'b0;
        if (expire) ctrl_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            modulus <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (mod_wr) modulus <= wr_data;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_CTRL: rd_data = W'(ctrl_to_word(ctrl_q));
            OFS_MOD:  rd_data = modulus;
            OFS_CNT:  rd_data = count;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int W   = CNT_W,
    parameter int AW  = ADDR_W,
    parameter int P_W = PRE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data,
    output logic          irq
);
    ctrl_t        ctrl_q;
    logic [W-1:0] modulus;
    logic [W-1:0] count;
    logic [W-1:0] limit;
    logic         restart;
    logic         ow_load;
    logic         step;
    logic         expire;
    cnt_op_e      op;

    pit_ctrl_regs #(.W(W), .AW(AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .expire  (expire),
        .count   (count),
        .ctrl_q  (ctrl_q),
        .modulus (modulus),
        .restart (restart),
        .ow_load (ow_load),
        .rd_data (rd_data)
    );

    pit_prescaler #(.P_W(P_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .run       (ctrl_q.en),
        .base_tick (tick_en),
        .shift     (ctrl_q.pre),
        .step      (step)
    );

    always_comb begin
        limit = ctrl_q.rld ? modulus : '1;
        if (restart)      op = ctrl_q.en || wr_data[BIT_EN] ? (wr_data[BIT_EN] ? OP_LOAD_LIMIT : OP_HOLD) : OP_HOLD;
        else if (ow_load) op = OP_LOAD_VALUE;
        else if (step)    op = OP_STEP;
        else              op = OP_HOLD;
    end

    // The limit on a restart comes from the newly written reload bit
    logic [W-1:0] cnt_limit;
    always_comb cnt_limit = restart ? (wr_data[BIT_RLD] ? modulus : '1) : limit;

    pit_downcount #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .limit    (cnt_limit),
        .load_val (wr_data),
        .count    (count),
        .expire   (expire)
    );

    always_comb irq = ctrl_q.flag && ctrl_q.ie;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
    import pit_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [2:0]  addr,
    input logic [15:0] wr_data,
    input logic        irq,
    input ctrl_t       ctrl_q,
    input logic [15:0] count,
    input logic        expire,
    input logic        restart,
    input logic        step
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && ctrl_q == '0));

    p_flag_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == OFS_CTRL || addr == OFS_MOD) && !expire) |=> !ctrl_q.flag);

    p_irq_level_r4: assert property (@(posedge clk) disable iff (rst)
        irq == (ctrl_q.flag && ctrl_q.ie));

    p_expire_zero_r6: assert property (@(posedge clk) disable iff (rst)
        expire |=> (count == '0 && ctrl_q.flag));

    p_hold_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !wr_en) |=> $stable(count));

    p_ie_only_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_CTRL && !ctrl_q.flag && !wr_data[BIT_FLAG] &&
         ((wr_data & 16'h0F73) == (ctrl_to_word(ctrl_q) & 16'h0F73))) |-> !restart);

    p_overwrite_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_MOD && ctrl_q.ovw) |=> count == $past(wr_data));

    p_count_ro_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_CNT && !step) |=> $stable(count));
endmodule

bind pit_timer pit_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .irq     (irq),
    .ctrl_q  (ctrl_q),
    .count   (count),
    .expire  (expire),
    .restart (restart),
    .step    (step)
);

// File: tb/pit_timer_test.sv
`timescale 1ns/1ps
module pit_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] d;
        logic        i;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    pit_timer uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Monitor: compares each queued expectation half a cycle after it is posted
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (rd_data !== e.d || irq !== e.i) begin
                n_fail++;
                $display("FAIL %s: addr=%0d rd_data=%h irq=%b expected rd_data=%h irq=%b",
                         e.req, addr, rd_data, irq, e.d, e.i);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit with_tick = 1'b0);
        wr_en = 1'b1; addr = a; wr_data = d; tick_en = with_tick;
        @(posedge clk); #1;
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [15:0] d, input logic i, input string req);
        exp_t e;
        addr = a;
        e.d = d; e.i = i; e.req = req;
        sb.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick_en = 1'b1;
            @(posedge clk); #1;
        end
        tick_en = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        chk(0, 16'h0000, 0, "R1");
        chk(2, 16'h0000, 0, "R1");
        chk(4, 16'h0000, 0, "R1");

        // R2 field layout, unused bits, flag never stored (R3)
        wr(0, 16'hF0FE);
        chk(0, 16'h007A, 0, "R2");
        wr(0, 16'h0F00);
        chk(0, 16'h0F00, 0, "R2");
        wr(0, 16'h0000);

        // R10 read-only count, unmapped offsets
        wr(6, 16'hFFFF);
        chk(6, 16'h0000, 0, "R10");
        wr(4, 16'h1234);
        chk(4, 16'h0000, 0, "R10");
        chk(0, 16'h0000, 0, "R10");
        chk(2, 16'h0000, 0, "R10");

        // R9 no overwrite; R7 enable restart; R6 reload sequence; R4 irq
        wr(2, 16'd5);
        chk(4, 16'd0, 0, "R9");
        chk(2, 16'd5, 0, "R9");
        wr(0, 16'h000B);
        chk(4, 16'd5, 0, "R7");
        ticks(4);
        chk(4, 16'd1, 0, "R6");
        ticks(1);
        chk(4, 16'd0, 1, "R6");
        chk(0, 16'h000F, 1, "R4");
        ticks(1);
        chk(4, 16'd5, 1, "R6");

        // R3 write-one-to-clear without restart; R8 IE-only write
        ticks(2);
        wr(0, 16'h000F);
        chk(0, 16'h000B, 0, "R3");
        chk(4, 16'd3, 0, "R8");
        wr(0, 16'h0003);
        chk(4, 16'd3, 0, "R8");
        chk(0, 16'h0003, 0, "R8");
        ticks(3);
        chk(0, 16'h0007, 0, "R4");
        wr(0, 16'h000B);
        chk(4, 16'd5, 0, "R7");
        chk(0, 16'h000B, 0, "R3");

        // R9 new modulus at next reload, flag clear, overwrite
        ticks(1);
        wr(2, 16'd9);
        chk(4, 16'd4, 0, "R9");
        chk(2, 16'd9, 0, "R9");
        ticks(4);
        ticks(1);
        chk(4, 16'd9, 1, "R9");
        wr(2, 16'd9);
        chk(0, 16'h000B, 0, "R9");
        wr(0, 16'h001B);
        wr(2, 16'h0020);
        chk(4, 16'h0020, 0, "R9");

        // R6 free-run limit
        wr(0, 16'h0011);
        chk(4, 16'hFFFF, 0, "R6");
        wr(2, 16'd3);
        chk(4, 16'd3, 0, "R9");
        ticks(3);
        ticks(1);
        chk(4, 16'hFFFF, 0, "R6");
        chk(0, 16'h0015, 0, "R6");

        // R7 disable holds count
        ticks(2);
        wr(0, 16'h0010);
        ticks(3);
        chk(4, 16'hFFFD, 0, "R7");
        chk(0, 16'h0010, 0, "R7");

        // R5 prescale 4, R8 phase kept, R7 phase reset
        wr(2, 16'd100);
        wr(0, 16'h0203);
        ticks(3);
        chk(4, 16'd100, 0, "R5");
        ticks(1);
        chk(4, 16'd99, 0, "R5");
        ticks(3);
        wr(0, 16'h020B);
        ticks(1);
        chk(4, 16'd98, 0, "R8");
        ticks(3);
        wr(0, 16'h0213);
        ticks(1);
        chk(4, 16'd100, 0, "R7");
        ticks(3);
        chk(4, 16'd99, 0, "R5");

        // R5 largest prescale
        wr(0, 16'h0F03);
        ticks(32767);
        chk(4, 16'd100, 0, "R5");
        ticks(1);
        chk(4, 16'd99, 0, "R5");

        // R3 expiry wins over a clearing write in the same cycle
        wr(0, 16'h001B);
        wr(2, 16'd1);
        wr(0, 16'h0013, 1'b1);
        chk(0, 16'h0017, 0, "R3");
        chk(4, 16'd0, 0, "R3");

        // R6 modulus zero expires on every step
        wr(2, 16'd0);
        wr(0, 16'h000B);
        chk(0, 16'h000B, 0, "R6");
        ticks(1);
        chk(0, 16'h000F, 1, "R6");
        chk(4, 16'd0, 1, "R6");

        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        report();
    end
endmodule